// File: doc/BRIEF.md
# Per-Cell Voltage Fault Classifier

This block watches a series stack of up to sixteen battery cells whose voltages arrive as digitized millivolt codes. For every cell it keeps three fault flags: overvoltage, undervoltage and broken sense connection (open-wire). Each flag sets at one level and releases at another, so a reading that hovers near a limit does not make the flag chatter. Limits come from static configuration pins. Voltage limits are given as step indices. Hysteresis width is picked from two fixed values.

The block owns the timing of the short open-wire test window. It drives a window signal that an analog pull-down stage can use. It judges the open-wire condition only on samples that arrive while that window is open, and keeps the verdict unchanged between windows. Open-wire is a neighbour comparison: a cell reading that drops well below the reading of the cell under it is flagged. For the bottom cell, the comparison is against ground. Per-cell flags and one registered OR of each fault type leave the block as plain status pins. Delay timing, pin drive and sensing are handled elsewhere.

Samples enter on a valid/ready stream. `in_ready` is held high, so the block takes a sample on every cycle that `in_valid` is high and never applies back-pressure. A cycle without `in_valid` changes no flag.

Top module: `cell_fault_classifier`

## Requirements
- R1: The overvoltage set level is 3550 mV + 25 mV × `ov_code`. Codes above 62 are treated as 62, which gives 5100 mV.
- R2: The undervoltage set level is 1000 mV + 50 mV × `uv_code`. Codes above 50 are treated as 50, which gives 3500 mV.
- R3: A cell's overvoltage flag sets when its code is strictly above the set level and clears when its code is strictly below the set level minus the hysteresis. Between those two levels the flag holds. `ov_hys_sel` 0 selects 100 mV and 1 selects 200 mV.
- R4: A cell's undervoltage flag sets when its code is strictly below the set level and clears when its code is strictly above the set level plus the hysteresis. Between those two levels the flag holds. `uv_hys_sel` 0 selects 100 mV and 1 selects 200 mV.
- R5: A cell reading below 500 mV clears its undervoltage flag and cannot set it.
- R6: For cell n ≥ 1, open-wire sets when code[n-1] − code[n] > 200 mV and clears when that difference is < 100 mV.
- R7: For cell 0, open-wire sets when its code is < 500 mV and clears when its code is > 600 mV.
- R8: Open-wire is evaluated only on a sample accepted while `ow_window` is high. Samples accepted outside the window leave the open-wire flags unchanged.
- R9: `ow_window` is high for the first OW_WIDTH_CYC cycles of every OW_PERIOD_CYC-cycle period. The first period starts in the first cycle after reset is released.
- R10: A sample accepted with `ow_en` low clears every open-wire flag.
- R11: Cells at index ≥ the effective count have all three flags cleared on every accepted sample. The effective count is `cell_count` clamped to the range 3 to NCELLS.
- R12: Per-cell flags and the `*_any` ORs change only on the clock edge that accepts a sample, so they are visible one cycle after `in_valid`. Each `*_any` output equals the OR of its per-cell vector. `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for `cell_mv` |
| in_ready | output | 1 | Always 1: a sample is taken on every valid cycle |
| cell_mv | input | NCELLS*16 | Unsigned mV code per cell; cell i occupies bits [16i+15:16i] |
| cell_count | input | $clog2(NCELLS+1) | Number of cells in use (clamped to 3..NCELLS) |
| ov_code | input | 6 | Overvoltage level index |
| ov_hys_sel | input | 1 | Overvoltage hysteresis: 0 = 100 mV, 1 = 200 mV |
| uv_code | input | 6 | Undervoltage level index |
| uv_hys_sel | input | 1 | Undervoltage hysteresis: 0 = 100 mV, 1 = 200 mV |
| ow_en | input | 1 | Open-wire detection enable |
| ow_window | output | 1 | Open-wire test window |
| ov_cell | output | NCELLS | Per-cell overvoltage flags |
| uv_cell | output | NCELLS | Per-cell undervoltage flags |
| ow_cell | output | NCELLS | Per-cell open-wire flags |
| ov_any | output | 1 | Registered OR of `ov_cell` |
| uv_any | output | 1 | Registered OR of `uv_cell` |
| ow_any | output | 1 | Registered OR of `ow_cell` |

## Verification
The bench builds the block with all sixteen cells, a 20-cycle open-wire period and a 6-cycle window. The full stack lets it probe count clamping at both ends, with cells left beyond the count. The short period puts several window openings and closings inside a brief run, so samples can be placed deliberately inside and outside the window. The threshold edges, both hysteresis widths, the clamped level codes and the bottom-cell ground comparison are each tested one millivolt on either side of the boundary.

// File: rtl/cellmon_pkg.sv
package cellmon_pkg;
  localparam int MV_W   = 16;
  localparam int CODE_W = 6;
  localparam int HYS_NARROW_MV = 100;
  localparam int HYS_WIDE_MV   = 200;
  typedef logic [MV_W-1:0] mv_t;
endpackage

// File: rtl/cellmon_thr_decode.sv
module cellmon_thr_decode
  import cellmon_pkg::*;
#(
  parameter int OV_BASE_MV  = 3550,
  parameter int OV_STEP_MV  = 25,
  parameter int OV_MAX_CODE = 62,
  parameter int UV_BASE_MV  = 1000,
  parameter int UV_STEP_MV  = 50,
  parameter int UV_MAX_CODE = 50
) (
  input  logic [CODE_W-1:0] ov_code,
  input  logic              ov_hys_sel,
  input  logic [CODE_W-1:0] uv_code,
  input  logic              uv_hys_sel,
  output mv_t               ov_set_mv,
  output mv_t               ov_clr_mv,
  output mv_t               uv_set_mv,
  output mv_t               uv_clr_mv
);
  localparam logic [CODE_W-1:0] OV_LIM = CODE_W'(OV_MAX_CODE);
  localparam logic [CODE_W-1:0] UV_LIM = CODE_W'(UV_MAX_CODE);
  localparam mv_t HYS_N = MV_W'(HYS_NARROW_MV);
  localparam mv_t HYS_W = MV_W'(HYS_WIDE_MV);

  logic [CODE_W-1:0] ov_idx, uv_idx;
  mv_t ov_hys, uv_hys;

  always_comb begin
    ov_idx    = (ov_code > OV_LIM) ? OV_LIM : ov_code;
    uv_idx    = (uv_code > UV_LIM) ? UV_LIM : uv_code;
    ov_hys    = ov_hys_sel ? HYS_W : HYS_N;
    uv_hys    = uv_hys_sel ? HYS_W : HYS_N;
    ov_set_mv = MV_W'(OV_BASE_MV) + MV_W'(OV_STEP_MV) * MV_W'(ov_idx);
    uv_set_mv = MV_W'(UV_BASE_MV) + MV_W'(UV_STEP_MV) * MV_W'(uv_idx);
    ov_clr_mv = ov_set_mv - ov_hys;
    uv_clr_mv = uv_set_mv + uv_hys;
  end
endmodule

// File: rtl/cellmon_ow_sched.sv
module cellmon_ow_sched #(
  parameter int PERIOD_CYC = 128000,
  parameter int WIDTH_CYC  = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic window
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] WID  = CW'(WIDTH_CYC);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign window = (phase < WID);

  AST_WIN_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> window) else $error("window did not reopen"); // R9
endmodule

// File: rtl/cellmon_cell_slice.sv
module cellmon_cell_slice
  import cellmon_pkg::*;
#(
  parameter bit IS_LOW    = 1'b0,
  parameter int OW_UP_MV  = 200,
  parameter int OW_LO_MV  = 500,
  parameter int OW_HYS_MV = 100,
  parameter int UV_MIN_MV = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic ow_sample,
  input  logic ow_en,
  input  logic active,
  input  mv_t  v,
  input  mv_t  v_below,
  input  mv_t  ov_set_mv,
  input  mv_t  ov_clr_mv,
  input  mv_t  uv_set_mv,
  input  mv_t  uv_clr_mv,
  output logic ov_q,
  output logic uv_q,
  output logic ow_q,
  output logic ov_d,
  output logic uv_d,
  output logic ow_d
);
  localparam int DW = MV_W + 2;
  // bottom cell compares against ground: v < LO  <=>  (0 - v) > -LO
  localparam logic signed [DW-1:0] OW_SET_LIM =
    DW'(IS_LOW ? -OW_LO_MV : OW_UP_MV);
  localparam logic signed [DW-1:0] OW_CLR_LIM =
    DW'(IS_LOW ? -(OW_LO_MV + OW_HYS_MV) : (OW_UP_MV - OW_HYS_MV));
  localparam mv_t UV_FLOOR = MV_W'(UV_MIN_MV);

  logic signed [DW-1:0] drop;
  assign drop = $signed({2'b00, v_below}) - $signed({2'b00, v});

  always_comb begin
    ov_d = ov_q;
    uv_d = uv_q;
    ow_d = ow_q;
    if (upd) begin
      if (!active) begin
        ov_d = 1'b0;
        uv_d = 1'b0;
        ow_d = 1'b0;
      end else begin
        if (v > ov_set_mv)      ov_d = 1'b1;
        else if (v < ov_clr_mv) ov_d = 1'b0;

        if (v < UV_FLOOR)       uv_d = 1'b0;
        else if (v < uv_set_mv) uv_d = 1'b1;
        else if (v > uv_clr_mv) uv_d = 1'b0;

        if (!ow_en)             ow_d = 1'b0;
        else if (ow_sample) begin
          if (drop > OW_SET_LIM)      ow_d = 1'b1;
          else if (drop < OW_CLR_LIM) ow_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
      ow_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      uv_q <= uv_d;
      ow_q <= ow_d;
    end
  end

  AST_OV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && active && v > ov_set_mv) |=> ov_q) else $error("ov not set"); // R3
  AST_OV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && active && v < ov_clr_mv) |=> !ov_q) else $error("ov not cleared"); // R3
  AST_UV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && v < UV_FLOOR) |=> !uv_q) else $error("uv below floor"); // R5
  AST_IDLE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !active) |=> (!ov_q && !uv_q && !ow_q)) else $error("ignored cell flagged"); // R11
  AST_OW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ow_en) |=> !ow_q) else $error("ow while disabled"); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({ov_q, uv_q, ow_q})) else $error("flag moved without sample"); // R12
  AST_OW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && active && ow_en && !ow_sample) |=> $stable(ow_q)) else $error("ow outside window"); // R8
endmodule

// File: rtl/cell_fault_classifier.sv
module cell_fault_classifier
  import cellmon_pkg::*;
#(
  parameter int NCELLS        = 16,
  parameter int MIN_CELLS     = 3,
  parameter int OW_PERIOD_CYC = 128000,
  parameter int OW_WIDTH_CYC  = 128,
  parameter int OW_UP_MV      = 200,
  parameter int OW_LO_MV      = 500,
  parameter int OW_HYS_MV     = 100,
  parameter int UV_MIN_MV     = 500,
  localparam int CNT_W        = $clog2(NCELLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCELLS*MV_W-1:0] cell_mv,
  input  logic [CNT_W-1:0]       cell_count,
  input  logic [CODE_W-1:0]      ov_code,
  input  logic                   ov_hys_sel,
  input  logic [CODE_W-1:0]      uv_code,
  input  logic                   uv_hys_sel,
  input  logic                   ow_en,
  output logic                   ow_window,
  output logic [NCELLS-1:0]      ov_cell,
  output logic [NCELLS-1:0]      uv_cell,
  output logic [NCELLS-1:0]      ow_cell,
  output logic                   ov_any,
  output logic                   uv_any,
  output logic                   ow_any
);
  localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(MIN_CELLS);
  localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(NCELLS);

  mv_t ov_set_mv, ov_clr_mv, uv_set_mv, uv_clr_mv;
  logic [CNT_W-1:0]  eff_count;
  logic [NCELLS-1:0] active;
  logic [NCELLS-1:0] ov_nxt, uv_nxt, ow_nxt;
  logic              ow_sample;

  assign in_ready  = 1'b1;
  assign ow_sample = in_valid && ow_window;

  always_comb begin
    if (cell_count < CNT_LO)      eff_count = CNT_LO;
    else if (cell_count > CNT_HI) eff_count = CNT_HI;
    else                          eff_count = cell_count;
  end

  cellmon_thr_decode i_thr (
    .ov_code   (ov_code),
    .ov_hys_sel(ov_hys_sel),
    .uv_code   (uv_code),
    .uv_hys_sel(uv_hys_sel),
    .ov_set_mv (ov_set_mv),
    .ov_clr_mv (ov_clr_mv),
    .uv_set_mv (uv_set_mv),
    .uv_clr_mv (uv_clr_mv)
  );

  cellmon_ow_sched #(
    .PERIOD_CYC(OW_PERIOD_CYC),
    .WIDTH_CYC (OW_WIDTH_CYC)
  ) i_sched (
    .clk   (clk),
    .rst_n (rst_n),
    .window(ow_window)
  );

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    mv_t v_here, v_under;
    assign v_here    = cell_mv[i*MV_W +: MV_W];
    assign active[i] = (CNT_W'(i) < eff_count);
    if (i == 0) begin : g_bottom
      assign v_under = '0;
    end else begin : g_upper
      assign v_under = cell_mv[(i-1)*MV_W +: MV_W];
    end

    cellmon_cell_slice #(
      .IS_LOW   (i == 0),
      .OW_UP_MV (OW_UP_MV),
      .OW_LO_MV (OW_LO_MV),
      .OW_HYS_MV(OW_HYS_MV),
      .UV_MIN_MV(UV_MIN_MV)
    ) i_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (in_valid),
      .ow_sample(ow_sample),
      .ow_en    (ow_en),
      .active   (active[i]),
      .v        (v_here),
      .v_below  (v_under),
      .ov_set_mv(ov_set_mv),
      .ov_clr_mv(ov_clr_mv),
      .uv_set_mv(uv_set_mv),
      .uv_clr_mv(uv_clr_mv),
      .ov_q     (ov_cell[i]),
      .uv_q     (uv_cell[i]),
      .ow_q     (ow_cell[i]),
      .ov_d     (ov_nxt[i]),
      .uv_d     (uv_nxt[i]),
      .ow_d     (ow_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_any <= 1'b0;
      uv_any <= 1'b0;
      ow_any <= 1'b0;
    end else begin
      ov_any <= |ov_nxt;
      uv_any <= |uv_nxt;
      ow_any <= |ow_nxt;
    end
  end

  AST_OV_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    ov_any == (|ov_cell)) else $error("ov_any mismatch"); // R12
  AST_UV_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any == (|uv_cell)) else $error("uv_any mismatch"); // R12
  AST_OW_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    ow_any == (|ow_cell)) else $error("ow_any mismatch"); // R12
endmodule

// File: tb/test_cell_fault_classifier.sv
module test_cell_fault_classifier;
  localparam int NC = 16;
  localparam int PER = 20;
  localparam int WID = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NC*16-1:0] cell_mv;
  logic [4:0] cell_count = 5'd16;
  logic [5:0] ov_code = 6'd30;
  logic ov_hys_sel = 1'b0;
  logic [5:0] uv_code = 6'd25;
  logic uv_hys_sel = 1'b0;
  logic ow_en = 1'b0;
  logic ow_window;
  logic [NC-1:0] ov_cell, uv_cell, ow_cell;
  logic ov_any, uv_any, ow_any;

  int checks = 0;
  int errors = 0;
  logic [15:0] cells [NC];

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < NC; i++) cell_mv[i*16 +: 16] = cells[i];

  cell_fault_classifier #(
    .NCELLS(NC), .OW_PERIOD_CYC(PER), .OW_WIDTH_CYC(WID)
  ) i_cell_fault_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cell_mv(cell_mv), .cell_count(cell_count), .ov_code(ov_code),
    .ov_hys_sel(ov_hys_sel), .uv_code(uv_code), .uv_hys_sel(uv_hys_sel),
    .ow_en(ow_en), .ow_window(ow_window), .ov_cell(ov_cell),
    .uv_cell(uv_cell), .ow_cell(ow_cell), .ov_any(ov_any),
    .uv_any(uv_any), .ow_any(ow_any)
  );

  // {cell 5 code, expected ov, expected uv}; ov level 4300 (clear <4200), uv level 2250 (clear >2350)
  localparam logic [17:0] VEC [14] = '{
    {16'd4300, 1'b0, 1'b0}, {16'd4301, 1'b1, 1'b0}, {16'd4250, 1'b1, 1'b0},
    {16'd4200, 1'b1, 1'b0}, {16'd4199, 1'b0, 1'b0}, {16'd3700, 1'b0, 1'b0},
    {16'd2250, 1'b0, 1'b0}, {16'd2249, 1'b0, 1'b1}, {16'd2300, 1'b0, 1'b1},
    {16'd2350, 1'b0, 1'b1}, {16'd2351, 1'b0, 1'b0}, {16'd2000, 1'b0, 1'b1},
    {16'd499,  1'b0, 1'b0}, {16'd2000, 1'b0, 1'b1}
  };

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic strobe();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_win(input logic lvl);
    while (ow_window !== lvl) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < NC; i++) cells[i] = 16'd3700;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R12 ready
    check("R12 in_ready", in_ready, 1);
    check("reset flags", int'(|{ov_cell, uv_cell, ow_cell, ov_any, uv_any, ow_any}), 0);
    // R9 window schedule
    bad = 0;
    for (int k = 0; k < 2*PER; k++) begin
      if (ow_window !== ((k % PER) < WID)) bad++;
      @(negedge clk);
    end
    check("R9 window pattern mismatches", bad, 0);

    strobe();
    // R3 R4 R5 table walk on cell 5
    for (int k = 0; k < 14; k++) begin
      cells[5] = VEC[k][17:2];
      strobe();
      check($sformatf("R3 ov vec %0d", k), ov_cell[5], VEC[k][1]);
      check($sformatf("R4 R5 uv vec %0d", k), uv_cell[5], VEC[k][0]);
      check($sformatf("R12 ov_any vec %0d", k), ov_any, VEC[k][1]);
      check($sformatf("R12 uv_any vec %0d", k), uv_any, VEC[k][0]);
    end
    cells[5] = 16'd3700; strobe();

    // R1 ov level decode and clamp
    ov_code = 6'd62; cells[5] = 16'd5100; strobe();
    check("R1 5100 at code 62", ov_cell[5], 0);
    cells[5] = 16'd5101; strobe();
    check("R1 5101 at code 62", ov_cell[5], 1);
    cells[5] = 16'd3700; strobe();
    ov_code = 6'd63; cells[5] = 16'd5101; strobe();
    check("R1 clamp code 63", ov_cell[5], 1);
    cells[5] = 16'd3700; strobe(); ov_code = 6'd30;

    // R2 uv level clamp
    uv_code = 6'd60; cells[5] = 16'd3500; strobe();
    check("R2 3500 at clamped code", uv_cell[5], 0);
    cells[5] = 16'd3499; strobe();
    check("R2 3499 at clamped code", uv_cell[5], 1);
    cells[5] = 16'd3700; strobe();
    check("R2 release above 3600", uv_cell[5], 0);
    uv_code = 6'd25;

    // R3 wide hysteresis
    ov_hys_sel = 1'b1;
    cells[5] = 16'd4301; strobe();
    cells[5] = 16'd4150; strobe();
    check("R3 wide hold 4150", ov_cell[5], 1);
    cells[5] = 16'd4099; strobe();
    check("R3 wide clear 4099", ov_cell[5], 0);
    ov_hys_sel = 1'b0;
    // R4 wide hysteresis
    uv_hys_sel = 1'b1;
    cells[5] = 16'd2249; strobe();
    cells[5] = 16'd2450; strobe();
    check("R4 wide hold 2450", uv_cell[5], 1);
    cells[5] = 16'd2451; strobe();
    check("R4 wide clear 2451", uv_cell[5], 0);
    uv_hys_sel = 1'b0;
    cells[5] = 16'd3700; strobe();

    // R12 no change without valid
    cells[5] = 16'd4500;
    repeat (2) @(negedge clk);
    check("R12 no valid no ov", ov_cell[5], 0);
    check("R12 no valid no ov_any", ov_any, 0);
    strobe();
    check("R12 valid sets ov", ov_cell[5], 1);
    cells[5] = 16'd3700; strobe();

    // R11 count handling
    cell_count = 5'd4; cells[10] = 16'd5000; strobe();
    check("R11 cell 10 ignored", ov_cell[10], 0);
    check("R11 ov_any ignored", ov_any, 0);
    cell_count = 5'd2; cells[2] = 16'd5000; cells[3] = 16'd5000; strobe();
    check("R11 clamp 3 cell 2", ov_cell[2], 1);
    check("R11 clamp 3 cell 3", ov_cell[3], 0);
    cell_count = 5'd20; strobe();
    check("R11 clamp 16 cell 10", ov_cell[10], 1);
    cells[2] = 16'd3700; cells[3] = 16'd3700; cells[10] = 16'd3700;
    cell_count = 5'd16; strobe();

    // R8 R6 open-wire on upper cell 7
    ow_en = 1'b1;
    cells[7] = 16'd3400;
    wait_win(1'b0); strobe();
    check("R8 outside window no ow", ow_cell[7], 0);
    wait_win(1'b1); strobe();
    check("R6 set diff 300", ow_cell[7], 1);
    check("R12 ow_any", ow_any, 1);
    cells[7] = 16'd3700;
    wait_win(1'b0); strobe();
    check("R8 hold outside window", ow_cell[7], 1);
    cells[7] = 16'd3550;
    wait_win(1'b1); strobe();
    check("R6 hold diff 150", ow_cell[7], 1);
    cells[7] = 16'd3601;
    wait_win(1'b1); strobe();
    check("R6 clear diff 99", ow_cell[7], 0);
    cells[7] = 16'd3500;
    wait_win(1'b1); strobe();
    check("R6 diff 200 no set", ow_cell[7], 0);
    cells[7] = 16'd3499;
    wait_win(1'b1); strobe();
    check("R6 diff 201 set", ow_cell[7], 1);
    cells[7] = 16'd3700;
    wait_win(1'b1); strobe();
    check("R6 clear healthy", ow_cell[7], 0);

    // R7 bottom cell
    cells[0] = 16'd500;
    wait_win(1'b1); strobe();
    check("R7 500 no set", ow_cell[0], 0);
    cells[0] = 16'd450;
    wait_win(1'b1); strobe();
    check("R7 450 set", ow_cell[0], 1);
    cells[0] = 16'd600;
    wait_win(1'b1); strobe();
    check("R7 600 hold", ow_cell[0], 1);
    cells[0] = 16'd601;
    wait_win(1'b1); strobe();
    check("R7 601 clear", ow_cell[0], 0);

    // R10 disable clears
    cells[0] = 16'd450;
    wait_win(1'b1); strobe();
    check("R10 precondition set", ow_cell[0], 1);
    ow_en = 1'b0;
    strobe();
    check("R10 disabled clears cell", ow_cell[0], 0);
    check("R10 disabled clears any", ow_any, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule